// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

This block is a 16-bit general-purpose timer controlled through a small register port. Software chooses a clock divisor and a reference value, then starts the count. The divisor is an 8-bit prescale field, plus an optional extra divide-by-16. The counter advances once per divided tick. When the counter arrives at the reference value, a sticky reference flag is set. If the interrupt enable is on, the flag drives the interrupt line. The counter can either run freely and wrap, or fall back to zero after the reference value, which gives a period of reference+1 ticks.

Register writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`. A write to the mode or reference register restarts both the prescaler and the count. A write to the counter register loads the count directly. The event register is write-one-to-clear. Clearing the run bit through a mode write also wipes the reference register. A capture register is provided as plain storage. The register port is a control interface with no handshake: every write is accepted in its cycle.

Top module: `refcmp_timer`

## Requirements
- R1: After reset, the mode, reference, capture, counter and event registers all read 0, and `irq` is low.
- R2: The mode register sits at offset 0x00 and the capture register at offset 0x08. Both read back what was written. Offsets that map no register read 0.
- R3: The mode register fields are: bit 0 run, bits 2:1 clock source, bit 3 restart-on-reference, bit 4 interrupt enable, bits 15:8 prescale. The tick divisor is prescale+1, multiplied by 16 when the clock source is 2. Counting happens only when run is 1 and the clock source is 1 or 2. Otherwise the counter and prescaler hold.
- R4: Each tick adds one to the counter, which wraps from 0xFFFF to 0. If restart-on-reference is set, a tick taken while the counter equals the reference returns it to 0.
- R5: Event bit 1 (the reference flag) is set on the tick that makes the counter equal to the reference register (offset 0x04).
- R6: The event register at offset 0x11 is write-one-to-clear: a 1 in bit 0 or bit 1 of the write data clears that bit, and a 0 leaves it unchanged. If a set and a clear of the reference flag fall in the same cycle, the flag stays set.
- R7: `irq` is high exactly when the interrupt enable and the reference flag are both 1.
- R8: A mode write that changes run from 1 to 0 clears the reference register. The mode register then holds the written value.
- R9: A mode or reference write resets the prescaler and the counter to 0. A write to offset 0x0C loads the counter, and that load takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Reference interrupt |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a reference match setting the flag and a software write clearing it. The second is a counter load and a tick. To provoke the first, the bench runs at divisor 1 with reference 5 and places a flag-clearing write exactly on the fifth tick after the restart. The flag and `irq` must still read 1 afterwards, while a clear one cycle later succeeds. To provoke the second, the bench loads the counter on a cycle where a tick is due. It then checks that the loaded value is read back unmodified and that counting resumes from it.

// File: rtl/refcmp_pkg.sv
package refcmp_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFF_MODE = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_REF  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_CAPT = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_EVT  = 5'h11;
  // mode field positions
  localparam int M_RUN     = 0;
  localparam int M_SRC     = 1;
  localparam int M_RESTART = 3;
  localparam int M_IEN     = 4;
  localparam int M_PRE     = 8;
  // event bits
  localparam int E_CAPT = 0;
  localparam int E_REF  = 1;
  typedef enum logic [1:0] {
    SRC_NONE0 = 2'd0,
    SRC_DIV1  = 2'd1,
    SRC_DIV16 = 2'd2,
    SRC_NONE3 = 2'd3
  } clk_src_e;
endpackage

// File: rtl/refcmp_regs.sv
module refcmp_regs
  import refcmp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              ref_hit,
  output logic              run,
  output logic [1:0]        src,
  output logic              wrap_on_ref,
  output logic              ien,
  output logic [PRE_W-1:0]  presc,
  output logic [CNT_W-1:0]  ref_q,
  output logic [1:0]        evt_q,
  output logic              restart_req,
  output logic              cnt_load
);
  localparam int MODE_W = M_PRE + PRE_W;

  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  capt_q;
  logic              wr_mode, wr_ref, wr_capt, wr_evt;
  logic [1:0]        evt_clr, evt_set;

  assign wr_mode = wr && (addr == OFF_MODE);
  assign wr_ref  = wr && (addr == OFF_REF);
  assign wr_capt = wr && (addr == OFF_CAPT);
  assign wr_evt  = wr && (addr == OFF_EVT);
  assign cnt_load    = wr && (addr == OFF_CNT);
  assign restart_req = wr_mode || wr_ref;

  assign evt_clr = wr_evt ? wdata[1:0] : 2'b00;
  assign evt_set = {ref_hit, 1'b0};

  assign run         = mode_q[M_RUN];
  assign src         = mode_q[M_SRC +: 2];
  assign wrap_on_ref = mode_q[M_RESTART];
  assign ien         = mode_q[M_IEN];
  assign presc       = mode_q[M_PRE +: PRE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '0;
      capt_q <= '0;
      evt_q  <= '0;
    end else begin
      if (wr_mode) begin
        mode_q <= wdata[MODE_W-1:0];
        if (mode_q[M_RUN] && !wdata[M_RUN]) ref_q <= '0;
      end
      if (wr_ref)  ref_q  <= wdata;
      if (wr_capt) capt_q <= wdata;
      // set has priority over a simultaneous clear
      evt_q <= (evt_q & ~evt_clr) | evt_set;
    end
  end

  always_comb begin
    case (addr)
      OFF_MODE: rdata = CNT_W'(mode_q);
      OFF_REF:  rdata = ref_q;
      OFF_CAPT: rdata = capt_q;
      OFF_CNT:  rdata = cnt_q;
      OFF_EVT:  rdata = CNT_W'(evt_q);
      default:  rdata = '0;
    endcase
  end

  // R8
  run_fall_clears_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && run && !wdata[M_RUN]) |=> (ref_q == '0));
  // R6
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_hit |=> evt_q[E_REF]);
endmodule

// File: rtl/refcmp_prescaler.sv
module refcmp_prescaler
  import refcmp_pkg::*;
#(
  parameter int PRE_W   = 8,
  parameter int SLOW_SH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       src,
  input  logic [PRE_W-1:0] presc,
  input  logic             restart,
  output logic             active,
  output logic             tick
);
  localparam int DIV_W = PRE_W + SLOW_SH + 1;

  logic [DIV_W-1:0] base, scaled, last, pcnt;

  assign base   = DIV_W'(presc) + DIV_W'(1);
  assign scaled = (src == SRC_DIV16) ? (base << SLOW_SH) : base;
  assign last   = scaled - DIV_W'(1);
  assign active = run && ((src == SRC_DIV1) || (src == SRC_DIV16));
  assign tick   = active && !restart && (pcnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pcnt <= '0;
    else if (active)       pcnt <= tick ? '0 : pcnt + DIV_W'(1);
  end

  // R3
  idle_holds_prescaler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !restart) |=> $stable(pcnt));
  // R9
  restart_zeroes_prescaler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pcnt == '0));
endmodule

// File: rtl/refcmp_counter.sv
module refcmp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             wrap_on_ref,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ref_hit
);
  logic [CNT_W-1:0] nxt;

  assign nxt     = (wrap_on_ref && (cnt_q == ref_val)) ? '0 : cnt_q + CNT_W'(1);
  assign ref_hit = tick && !restart && !load && (nxt == ref_val);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (tick)         cnt_q <= nxt;
  end

  // R4
  wrap_at_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !restart && wrap_on_ref && (cnt_q == ref_val)) |=> (cnt_q == '0));
  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !restart) |=> (cnt_q == $past(load_val)));
  // R3
  idle_holds_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/refcmp_timer.sv
module refcmp_timer
  import refcmp_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 8,
  parameter int SLOW_SH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  logic             run, wrap_on_ref, ien, restart_req, cnt_load, active, tick, ref_hit;
  logic [1:0]       src, evt_q;
  logic [PRE_W-1:0] presc;
  logic [CNT_W-1:0] ref_q, cnt_q;

  refcmp_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .cnt_q(cnt_q), .ref_hit(ref_hit), .run(run), .src(src),
    .wrap_on_ref(wrap_on_ref), .ien(ien), .presc(presc), .ref_q(ref_q),
    .evt_q(evt_q), .restart_req(restart_req), .cnt_load(cnt_load)
  );

  refcmp_prescaler #(.PRE_W(PRE_W), .SLOW_SH(SLOW_SH)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .src(src), .presc(presc),
    .restart(restart_req), .active(active), .tick(tick)
  );

  refcmp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart_req), .load(cnt_load),
    .load_val(bus_wdata), .ref_val(ref_q), .wrap_on_ref(wrap_on_ref),
    .cnt_q(cnt_q), .ref_hit(ref_hit)
  );

  assign irq = ien & evt_q[E_REF];

  // R7
  clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == OFF_EVT) && bus_wdata[E_REF] && !ref_hit) |=> !irq);
  // R3
  no_tick_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !tick);
endmodule

// File: tb/test_refcmp_timer.sv
`timescale 1ns/1ps
module test_refcmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  refcmp_timer i_refcmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [4:0] A_MODE = 5'h00, A_REF = 5'h04, A_CAPT = 5'h08,
                         A_CNT = 5'h0C, A_EVT = 5'h11;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_MODE, v); chk("R1 mode", v, 16'h0);
    rd(A_REF, v);  chk("R1 ref", v, 16'h0);
    rd(A_CAPT, v); chk("R1 capt", v, 16'h0);
    rd(A_CNT, v);  chk("R1 cnt", v, 16'h0);
    rd(A_EVT, v);  chk("R1 evt", v, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    // R2 plain storage and unmapped offsets
    wr(A_CAPT, 16'hBEEF);
    rd(A_CAPT, v); chk("R2 capt", v, 16'hBEEF);
    wr(A_MODE, 16'hA5C0);
    rd(A_MODE, v); chk("R2 mode", v, 16'hA5C0);
    rd(5'h14, v);  chk("R2 unmapped", v, 16'h0);

    // R3 R4 R5 R7 sweep: prescale x source x restart x reference
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        for (int rs = 0; rs < 2; rs++)
          for (int ri = 0; ri < 2; ri++) begin
            int refv, dv, ticks, ecnt, eflag;
            bit act;
            refv = (ri == 0) ? 1 : 3;
            act = (s == 1) || (s == 2);
            dv = (p + 1) * ((s == 2) ? 16 : 1);
            wr(A_MODE, 16'h0000);
            wr(A_EVT, 16'h0003);
            wr(A_REF, 16'(refv));
            wr(A_MODE, 16'((p << 8) | (1 << 4) | (rs << 3) | (s << 1) | 1));
            repeat (150) @(negedge clk);
            ticks = act ? 150 / dv : 0;
            ecnt  = rs ? ticks % (refv + 1) : ticks;
            eflag = (ticks >= refv) ? 1 : 0;
            rd(A_CNT, v); chk("R3/R4 count", v, 16'(ecnt));
            rd(A_EVT, v); chk("R5 flag", v, 16'(eflag << 1));
            chk("R7 irq", {15'b0, irq}, 16'(eflag));
          end

    // R6 collision: clear lands on the matching tick
    wr(A_MODE, 16'h0000);
    wr(A_EVT, 16'h0003);
    wr(A_REF, 16'd5);
    wr(A_MODE, 16'h001B);
    repeat (3) @(negedge clk);
    wr(A_EVT, 16'h0002);
    rd(A_CNT, v); chk("R6 cnt at match", v, 16'd5);
    rd(A_EVT, v); chk("R6 set beats clear", v, 16'h0002);
    chk("R7 irq collision", {15'b0, irq}, 16'h1);
    wr(A_EVT, 16'h0002);
    rd(A_EVT, v); chk("R6 later clear", v, 16'h0000);

    // R6 zeros leave, R7 enable gating
    repeat (10) @(negedge clk);
    wr(A_MODE, 16'h0019);
    rd(A_EVT, v); chk("R6 flag kept", v, 16'h0002);
    wr(A_EVT, 16'h0000);
    rd(A_EVT, v); chk("R6 zero write", v, 16'h0002);
    wr(A_EVT, 16'h0001);
    rd(A_EVT, v); chk("R6 other bit", v, 16'h0002);
    wr(A_MODE, 16'h0009);
    chk("R7 irq disabled", {15'b0, irq}, 16'h0);
    wr(A_MODE, 16'h0019);
    chk("R7 irq enabled", {15'b0, irq}, 16'h1);
    wr(A_EVT, 16'h0002);
    chk("R7 irq after clear", {15'b0, irq}, 16'h0);

    // R3 hold while no source
    wr(A_CNT, 16'h1234);
    repeat (20) @(negedge clk);
    rd(A_CNT, v); chk("R3 hold", v, 16'h1234);
    rd(A_REF, v); chk("R8 ref kept", v, 16'd5);

    // R8 run falling clears reference
    wr(A_MODE, 16'h0018);
    rd(A_REF, v);  chk("R8 ref cleared", v, 16'h0);
    rd(A_MODE, v); chk("R8 mode stored", v, 16'h0018);

    // R9 load beats tick, restart on writes, R4 free wrap
    wr(A_REF, 16'd16);
    wr(A_MODE, 16'h0003);
    wr(A_CNT, 16'h0040);
    rd(A_CNT, v); chk("R9 load wins", v, 16'h0040);
    repeat (5) @(negedge clk);
    rd(A_CNT, v); chk("R9 resume", v, 16'h0045);
    wr(A_CNT, 16'hFFFE);
    repeat (3) @(negedge clk);
    rd(A_CNT, v); chk("R4 wrap", v, 16'h0001);
    wr(A_REF, 16'd16);
    rd(A_CNT, v); chk("R9 ref write restart", v, 16'h0000);
    repeat (4) @(negedge clk);
    wr(A_MODE, 16'h0003);
    rd(A_CNT, v); chk("R9 mode write restart", v, 16'h0000);

    finish_run();
  end
endmodule